// File: doc/BRIEF.md
# Bit-Addressed Nonvolatile Programming Sequencer

This block sequences programming of a 128-bit nonvolatile store that is modelled here as a bank of registers. The store has no word write. It can be cleared as a whole to zero, and after that single bits can be raised to one. Each bit set is framed by a begin-write request and an end-write request. After every operation the caller must wait out a timed interval before the next request is allowed.

Requests arrive already decoded: erase, begin-write and end-write, each a single-cycle pulse. A 12-bit data field goes with them, and its low seven bits select one bit of the store. The sequencer allows a programming request only when both the write-enable and the chip-select inputs are high and no interval is running. It times the erase, program and settle intervals with counters whose lengths are parameters, and it holds `busy_o` high for the whole of each interval. Requests it refuses are dropped and raise a sticky error flag. A separate read request returns the bit at a given address on the next cycle, and reads are allowed while an interval is running.

The store is laid out as eight 16-bit words. Bit address `a` sits in word `a[6:4]` at position `a[3:0]`. A typical flow is: erase, end-write at address 0, then a begin-write and end-write pair for each bit that must be one, and finally a read-back of all 128 addresses.

Top module: `bitprog_seq`

## Requirements
- R1: After reset `busy_o`, `err_o`, `seq_err_o` and `rd_bit_o` are 0 and every one of the 128 bits reads 0.
- R2: An erase request (`erase_req_i`) accepted with `we_i` and `cs_i` high while idle holds `busy_o` high for exactly ERASE_CYC cycles, starting the cycle after the request, and leaves all 128 bits at 0. The data field has no effect on it.
- R3: An accepted begin-write (`begin_req_i`) holds `busy_o` high for exactly PROG_CYC cycles. When the interval ends, the bit at address `data_i[6:0]` is 1 and every other bit is unchanged. `data_i[11:7]` is ignored.
- R4: An accepted end-write (`end_req_i`) holds `busy_o` high for exactly SETTLE_CYC cycles and changes no bit of the store.
- R5: A programming request made while `we_i` or `cs_i` is low is dropped. `busy_o` stays low, the store is unchanged and `err_o` becomes 1.
- R6: A programming request made while `busy_o` is high is dropped and sets `err_o`. The running interval keeps its length and the store does not see the dropped request.
- R7: `err_o` and `seq_err_o` are sticky and return to 0 only through reset.
- R8: An end-write whose address differs from the address of the begin-write still pending sets `seq_err_o`, and the begun bit is still set. An end-write with no begin-write pending (for example the one at address 0 after an erase) raises no sequence error.
- R9: A read request (`rd_req_i`) made with `cs_i` high puts the bit at `data_i[6:0]` on `rd_bit_o` one cycle later, ignoring `data_i[11:7]`, even while busy. With `cs_i` low, a read request leaves `rd_bit_o` unchanged.
- R10: When several programming requests arrive in one cycle, only the highest is taken, in the order erase, then begin-write, then end-write. The others are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write enable for programming requests |
| cs_i | input | 1 | Chip select; gates programming requests and reads |
| erase_req_i | input | 1 | Bulk-clear request pulse |
| begin_req_i | input | 1 | Begin-write (bit set) request pulse |
| end_req_i | input | 1 | End-write request pulse |
| rd_req_i | input | 1 | Single-bit read request pulse |
| data_i | input | 12 | Data field; bits 6:0 give the bit address |
| busy_o | output | 1 | High while an erase, program or settle interval runs |
| rd_bit_o | output | 1 | Bit returned by the last accepted read |
| err_o | output | 1 | Sticky flag for dropped programming requests |
| seq_err_o | output | 1 | Sticky flag for mismatched end-write address |

## Verification
The assertions take each request to be a pulse that is sampled on a clock edge. They also take the parameters to give intervals of at least one cycle. Under those conditions `busy_o` cannot fall while a counter is still running, and a clear and a bit set never fall in the same cycle. The directed stimulus changes inputs only on falling edges. It holds each request for exactly one cycle. It issues a request during a busy interval only where the test means the request to be dropped. The bench runs with shortened interval counts so that every interval length can be counted cycle by cycle.

// File: rtl/bitprog_pkg.sv
package bitprog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_PROG   = 2'd2,
        ST_SETTLE = 2'd3
    } prog_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_BEGIN = 2'd2,
        OP_END   = 2'd3
    } prog_op_e;

endpackage

// File: rtl/prog_req_arb.sv
module prog_req_arb
    import bitprog_pkg::*;
(
    input  logic     erase_req_i,
    input  logic     begin_req_i,
    input  logic     end_req_i,
    output prog_op_e op_o
);
    // Fixed priority: bulk clear wins, then begin-write, then end-write
    always_comb begin
        if (erase_req_i)      op_o = OP_ERASE;
        else if (begin_req_i) op_o = OP_BEGIN;
        else if (end_req_i)   op_o = OP_END;
        else                  op_o = OP_NONE;
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R2 a freshly loaded nonzero count is not yet done
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && (load_val_i != '0) |=> !done_o);
endmodule

// File: rtl/bit_bank.sv
module bit_bank #(
    parameter int ARRAY_BITS = 128,
    parameter int WORD_BITS  = 16,
    localparam int ADDR_W    = $clog2(ARRAY_BITS),
    localparam int LSB_W     = $clog2(WORD_BITS),
    localparam int NWORDS    = ARRAY_BITS / WORD_BITS,
    localparam int WSEL_W    = ADDR_W - LSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              set_en_i,
    input  logic [ADDR_W-1:0] set_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_bit_o
);
    logic [ARRAY_BITS-1:0] bits_flat;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_BITS-1:0] word_d, word_q;
        logic                 hit;

        assign hit = set_en_i && (set_addr_i[ADDR_W-1:LSB_W] == WSEL_W'(w));

        always_comb begin
            word_d = word_q;
            if (clr_i)     word_d = '0;
            else if (hit)  word_d[set_addr_i[LSB_W-1:0]] = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign bits_flat[w*WORD_BITS +: WORD_BITS] = word_q;
    end

    assign rd_bit_o = bits_flat[rd_addr_i];

    // R2
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bits_flat == '0));
    // R3
    bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i && !clr_i |=> bits_flat[$past(set_addr_i)]);
    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !set_en_i |=> $stable(bits_flat));
    // R3 a single set raises at most one bit
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i && !clr_i |=> ($countones(bits_flat ^ $past(bits_flat)) <= 1));
endmodule

// File: rtl/bitprog_seq.sv
module bitprog_seq
    import bitprog_pkg::*;
#(
    parameter int ARRAY_BITS = 128,
    parameter int WORD_BITS  = 16,
    parameter int DATA_W     = 12,
    parameter int ERASE_CYC  = 40,
    parameter int PROG_CYC   = 40,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              cs_i,
    input  logic              erase_req_i,
    input  logic              begin_req_i,
    input  logic              end_req_i,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              rd_bit_o,
    output logic              err_o,
    output logic              seq_err_o
);
    localparam int ADDR_W  = $clog2(ARRAY_BITS);
    localparam int MAX_A   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_CYC = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] ERASE_LD  = TMR_W'(ERASE_CYC - 1);
    localparam logic [TMR_W-1:0] PROG_LD   = TMR_W'(PROG_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

    typedef struct packed {
        prog_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic              err;
        logic              seq_err;
        logic              rd_bit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    prog_op_e          op;
    logic [ADDR_W-1:0] req_addr;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              bank_clr, bank_set, bank_rd;
    logic              gate_ok, idle;
    logic              unused_hi;

    assign req_addr  = data_i[ADDR_W-1:0];
    assign unused_hi = ^data_i[DATA_W-1:ADDR_W];

    prog_req_arb u_arb (
        .erase_req_i (erase_req_i),
        .begin_req_i (begin_req_i),
        .end_req_i   (end_req_i),
        .op_o        (op)
    );

    interval_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    bit_bank #(.ARRAY_BITS(ARRAY_BITS), .WORD_BITS(WORD_BITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (bank_clr),
        .set_en_i   (bank_set),
        .set_addr_i (ctl_q.addr),
        .rd_addr_i  (req_addr),
        .rd_bit_o   (bank_rd)
    );

    assign gate_ok = we_i && cs_i;
    assign idle    = (ctl_q.st == ST_IDLE);

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        bank_clr = 1'b0;
        bank_set = 1'b0;

        // Interval completion; a program interval commits its bit here
        if (!idle && tmr_done) begin
            if (ctl_q.st == ST_PROG) bank_set = 1'b1;
            ctl_d.st = ST_IDLE;
        end

        if (op != OP_NONE) begin
            if (!gate_ok || !idle) begin
                ctl_d.err = 1'b1;
            end else begin
                case (op)
                    OP_ERASE: begin
                        ctl_d.st   = ST_ERASE;
                        ctl_d.pend = 1'b0;
                        bank_clr   = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = ERASE_LD;
                    end
                    OP_BEGIN: begin
                        ctl_d.st   = ST_PROG;
                        ctl_d.addr = req_addr;
                        ctl_d.pend = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = PROG_LD;
                    end
                    OP_END: begin
                        if (ctl_q.pend && (req_addr != ctl_q.addr))
                            ctl_d.seq_err = 1'b1;
                        ctl_d.st   = ST_SETTLE;
                        ctl_d.pend = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = SETTLE_LD;
                    end
                    default: ;
                endcase
            end
        end

        if (cs_i && rd_req_i) ctl_d.rd_bit = bank_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, pend: 1'b0, err: 1'b0,
                       seq_err: 1'b0, rd_bit: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = !idle;
    assign rd_bit_o  = ctl_q.rd_bit;
    assign err_o     = ctl_q.err;
    assign seq_err_o = ctl_q.seq_err;

    // R2 R3 R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tmr_done |=> busy_o);
    // R5
    gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !gate_ok |=> !busy_o);
    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (op != OP_NONE) |=> err_o);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R7
    seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o |=> seq_err_o);
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> $stable(rd_bit_o));
    // R3 clear and bit set never coincide
    clr_set_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_clr && bank_set));
endmodule

// File: tb/sim_bitprog_seq.sv
module sim_bitprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int E_CYC = 12;
    localparam int P_CYC = 10;
    localparam int S_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_i = 1'b0, cs_i = 1'b0;
    logic        erase_req_i = 1'b0, begin_req_i = 1'b0, end_req_i = 1'b0;
    logic        rd_req_i = 1'b0;
    logic [11:0] data_i = '0;
    logic        busy_o, rd_bit_o, err_o, seq_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitprog_seq #(.ERASE_CYC(E_CYC), .PROG_CYC(P_CYC), .SETTLE_CYC(S_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .we_i(we_i), .cs_i(cs_i),
        .erase_req_i(erase_req_i), .begin_req_i(begin_req_i),
        .end_req_i(end_req_i), .rd_req_i(rd_req_i), .data_i(data_i),
        .busy_o(busy_o), .rd_bit_o(rd_bit_o), .err_o(err_o),
        .seq_err_o(seq_err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        we_i = 1'b1; cs_i = 1'b1;
        erase_req_i = 0; begin_req_i = 0; end_req_i = 0; rd_req_i = 0;
        data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        @(negedge clk);
    endtask

    // Drives one request for one cycle; called and returns at a falling edge
    task automatic issue(input bit e, input bit b, input bit en, input logic [11:0] d);
        erase_req_i = e; begin_req_i = b; end_req_i = en; data_i = d;
        @(negedge clk);
        erase_req_i = 0; begin_req_i = 0; end_req_i = 0;
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_bit(input logic [11:0] d, output logic v);
        rd_req_i = 1'b1; data_i = d;
        @(negedge clk);
        rd_req_i = 1'b0;
        v = rd_bit_o;
    endtask

    task automatic read_all(input string tag);
        int bad = 0;
        logic v;
        for (int a = 0; a < 128; a++) begin
            read_bit(12'(a), v);
            if (v !== model[a]) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic program_bit(input logic [11:0] d, input string tag);
        int n;
        issue(0, 1, 0, d);
        measure_busy(n);
        check(n == P_CYC, tag, n, P_CYC);
        issue(0, 0, 1, d);
        measure_busy(n);
        check(n == S_CYC, tag, n, S_CYC);
        model[d[6:0]] = 1'b1;
    endtask

    task automatic t_reset();
        logic v;
        check(busy_o == 0 && err_o == 0 && seq_err_o == 0 && rd_bit_o == 0,
              "R1 outputs after reset", {busy_o, err_o, seq_err_o, rd_bit_o}, 0);
        read_all("R1 store reads zero after reset");
        read_bit(12'd127, v);
        check(v == 0, "R1 top address zero", v, 0);
    endtask

    task automatic t_erase_flow();
        int n;
        issue(1, 0, 0, 12'hFFF);
        measure_busy(n);
        check(n == E_CYC, "R2 erase interval", n, E_CYC);
        read_all("R2 all bits zero after erase");
        issue(0, 0, 1, 12'h000);
        measure_busy(n);
        check(n == S_CYC, "R4 end-write settle interval", n, S_CYC);
        check(seq_err_o == 0, "R8 end-write with no pending begin", seq_err_o, 0);
        read_all("R4 settle leaves store unchanged");
    endtask

    task automatic t_program();
        logic v;
        program_bit(12'hFA5, "R3 program addr 0x25 upper bits set");
        program_bit(12'h07F, "R3 program addr 127");
        program_bit(12'h000, "R3 program addr 0");
        read_bit(12'h025, v);
        check(v == 1, "R3 addr 0x25 set", v, 1);
        read_bit(12'h024, v);
        check(v == 0, "R3 neighbour 0x24 untouched", v, 0);
        read_bit(12'hF26, v);
        check(v == 0, "R9 read ignores upper bits (0x26)", v, 0);
        read_bit(12'hA25, v);
        check(v == 1, "R9 read ignores upper bits (0x25)", v, 1);
        read_all("R3 full read-back");
        check(err_o == 0 && seq_err_o == 0, "R8 clean flow no errors",
              {err_o, seq_err_o}, 0);
    endtask

    task automatic t_gate();
        logic v;
        we_i = 1'b0;
        issue(0, 1, 0, 12'd10);
        check(busy_o == 0, "R5 begin dropped with we low", busy_o, 0);
        check(err_o == 1, "R5 err raised", err_o, 1);
        we_i = 1'b1; cs_i = 1'b0;
        issue(1, 0, 0, 12'd0);
        check(busy_o == 0, "R5 erase dropped with cs low", busy_o, 0);
        cs_i = 1'b1;
        repeat (P_CYC + 2) @(negedge clk);
        read_bit(12'd10, v);
        check(v == 0, "R5 dropped begin left bit 10 clear", v, 0);
        read_all("R5 store unchanged after dropped erase");
        program_bit(12'd20, "R7 later op");
        check(err_o == 1, "R7 err stays set", err_o, 1);
    endtask

    task automatic t_busy_drop();
        int n;
        logic v;
        apply_reset();
        check(err_o == 0, "R7 err cleared by reset", err_o, 0);
        issue(0, 1, 0, 12'd3);
        issue(1, 0, 0, 12'd0);
        check(err_o == 1, "R6 erase during program flagged", err_o, 1);
        measure_busy(n);
        check(n + 1 == P_CYC, "R6 interval length kept", n + 1, P_CYC);
        read_bit(12'd3, v);
        check(v == 1, "R6 bit 3 set, erase not applied", v, 1);
        issue(0, 0, 1, 12'd3);
        measure_busy(n);
        model[3] = 1'b1;
    endtask

    task automatic t_seq();
        int n;
        logic v;
        apply_reset();
        issue(0, 1, 0, 12'd50);
        measure_busy(n);
        issue(0, 0, 1, 12'd51);
        check(seq_err_o == 1, "R8 mismatched end-write flagged", seq_err_o, 1);
        measure_busy(n);
        read_bit(12'd50, v);
        check(v == 1, "R8 begun bit still committed", v, 1);
        read_bit(12'd51, v);
        check(v == 0, "R8 end address bit not set", v, 0);
        program_bit(12'd60, "R7 later op");
        check(seq_err_o == 1, "R7 seq_err stays set", seq_err_o, 1);
        check(err_o == 0, "R8 no gate error", err_o, 0);
    endtask

    task automatic t_read_misc();
        logic v;
        read_bit(12'd51, v);
        check(v == 0, "R9 prime read 0", v, 0);
        cs_i = 1'b0;
        read_bit(12'd50, v);
        check(v == 0, "R9 read with cs low ignored", v, 0);
        cs_i = 1'b1;
        issue(0, 1, 0, 12'd70);
        read_bit(12'd50, v);
        check(v == 1, "R9 read while busy", v, 1);
        while (busy_o) @(negedge clk);
        issue(0, 0, 1, 12'd70);
        while (busy_o) @(negedge clk);
    endtask

    task automatic t_priority();
        int n;
        logic v;
        issue(1, 1, 1, 12'd80);
        measure_busy(n);
        check(n == E_CYC, "R10 erase wins over begin/end", n, E_CYC);
        check(err_o == 0, "R10 losers not flagged", err_o, 0);
        read_bit(12'd80, v);
        check(v == 0, "R10 begin not applied", v, 0);
        read_bit(12'd50, v);
        check(v == 0, "R10 erase cleared bit 50", v, 0);
        issue(0, 1, 1, 12'd81);
        measure_busy(n);
        check(n == P_CYC, "R10 begin wins over end", n, P_CYC);
        issue(0, 0, 1, 12'd81);
        measure_busy(n);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset();
        t_reset();
        t_erase_flow();
        t_program();
        t_gate();
        t_busy_drop();
        t_seq();
        t_read_misc();
        t_priority();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule